// File: doc/BRIEF.md
# Event-Reloaded Watchdog Countdown Timer

This block is a host-programmed watchdog. Software writes an 8-bit timeout through a small register port. The block then counts that value down, one step per second or one step per minute, and raises a time-out status flag when the count runs out. The status flag drives a level interrupt. Time is taken from a one-cycle `tick_1s` strobe that arrives once per second. In minute mode a divide-by-60 prescaler sits between that strobe and the counter.

Three system-event inputs can restart the countdown: a keyboard interrupt, a mouse interrupt and an access to the joystick port. Each event has its own enable bit. An enabled event reloads the counter from the stored timeout and clears the status flag. The host can also set or clear the status flag directly, or force an immediate time-out.

The timer is a three-state machine:
- **IDLE**: the stored timeout is zero, so the timer is disabled.
- **COUNT**: the timer is counting down.
- **EXPIRED**: the count is zero and the counter is stopped.

The transitions are:
- **start**: a non-zero timeout write, or an enabled event with a non-zero stored timeout, moves the machine to COUNT from any state.
- **disable**: a zero timeout write, or an enabled event with a zero stored timeout, moves it to IDLE.
- **run-out**: in COUNT, a step taken while the count is 1 moves it to EXPIRED.
- **force**: a control write with the force bit set moves it to EXPIRED from any state.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low.
- R2: The register map is as follows. Writes take effect on the clock edge; reads are combinational on `rdata`.
  - Address 0 is the timeout. It reads back as the full byte.
  - Address 1 is the units register. Only bit 7 is kept: 1 selects minutes, 0 selects seconds.
  - Address 2 is control. Bit 0 is the status flag and bit 2 is force; only bit 0 reads back.
  - Address 3 is configuration. Bits 0, 1 and 2 enable events `sys_evt[0]` (keyboard), `sys_evt[1]` (mouse) and `sys_evt[2]` (port access); only those bits read back.
- R3: While the stored timeout is 0x00, no number of `tick_1s` strobes sets the status flag.
- R4: Writing a non-zero timeout N, in seconds mode, restarts the count. The status flag then rises on the Nth following `tick_1s` strobe and not before.
- R5: In minutes mode each count step takes 60 strobes. The prescaler restarts on every timeout write and on every enabled event.
- R6: When the count reaches zero, the status flag is set and the counter stays stopped. Further strobes do not restart it.
- R7: A host write to control bit 0 sets or clears the status flag, whatever the counter state.
- R8: An enabled event reloads the counter from the stored timeout and clears the status flag. An event whose enable bit is 0 has no effect.
- R9: Writing 1 to control bit 2 zeroes the count and sets the status flag on the same edge. The force bit always reads back as 0.
- R10: `irq` equals the status flag at all times.
- R11: If an enabled event and the final decrement fall on the same cycle, the reload wins and the status flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| sys_evt | input | 3 | Event pulses: keyboard, mouse, port access |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The assertions take two things for granted: `tick_1s` and the event inputs are single-cycle pulses, and only one register is written per cycle. The priority checks also assume that a timeout write or a control write never lands in the same cycle as an event. The bench respects all of this. It drives every strobe, event and write for exactly one cycle from a falling edge. The only place it deliberately overlaps inputs is the event-versus-decrement race, where it pulses a tick together with an enabled event.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;

    localparam logic [1:0] A_TIMEOUT = 2'd0;
    localparam logic [1:0] A_UNITS   = 2'd1;
    localparam logic [1:0] A_CTRL    = 2'd2;
    localparam logic [1:0] A_CFG     = 2'd3;

    localparam int CTRL_STATUS_BIT = 0;
    localparam int CTRL_FORCE_BIT  = 2;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int NUM_EV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [VAL_W-1:0]  wdata,
    input  logic [NUM_EV-1:0] sys_evt,
    input  logic              status,
    output logic [VAL_W-1:0]  load_val,
    output logic              minutes,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              wr_status,
    output logic              wr_force,
    output logic              event_hit,
    output logic [VAL_W-1:0]  rdata
);
    logic [NUM_EV-1:0] ev_en;

    assign load_wr   = wr_en && (addr == A_TIMEOUT);
    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign wr_status = wdata[CTRL_STATUS_BIT];
    assign wr_force  = wdata[CTRL_FORCE_BIT];
    assign event_hit = |(sys_evt & ev_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_val <= '0;
            minutes  <= 1'b0;
            ev_en    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_TIMEOUT: load_val <= wdata;
                A_UNITS:   minutes  <= wdata[VAL_W-1];
                A_CFG:     ev_en    <= wdata[NUM_EV-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_TIMEOUT: rdata = load_val;
            A_UNITS:   rdata[VAL_W-1] = minutes;
            A_CTRL:    rdata[CTRL_STATUS_BIT] = status;
            A_CFG:     rdata[NUM_EV-1:0] = ev_en;
            default:   rdata = '0;
        endcase
    end

    // r2: a configuration write is visible on the next cycle
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CFG) |=> (ev_en == $past(wdata[NUM_EV-1:0])));
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic minutes,
    output logic step
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);
    assign step    = tick && (!minutes || at_last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && minutes) begin
            cnt <= at_last ? '0 : cnt + CW'(1);
        end
    end

    p_presc_range_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    p_presc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] new_val,
    input  logic [VAL_W-1:0] load_val,
    input  logic             load_wr,
    input  logic             ctrl_wr,
    input  logic             wr_status,
    input  logic             wr_force,
    input  logic             event_hit,
    input  logic             step,
    output logic             status
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    wd_state_e        state, state_n;
    logic [VAL_W-1:0] cnt, cnt_n;
    logic             status_n;
    logic             run_out;

    assign run_out = (state == ST_COUNT) && step && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            status <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            status <= status_n;
        end
    end

    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        status_n = status;
        if (load_wr) begin
            cnt_n   = new_val;
            state_n = (new_val != '0) ? ST_COUNT : ST_IDLE;
        end else if (ctrl_wr && wr_force) begin
            cnt_n   = '0;
            state_n = ST_EXPIRED;
        end else if (event_hit) begin
            cnt_n   = load_val;
            state_n = (load_val != '0) ? ST_COUNT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    ;
                ST_COUNT: begin
                    if (step) begin
                        cnt_n = cnt - ONE;
                        if (cnt == ONE) state_n = ST_EXPIRED;
                    end
                end
                ST_EXPIRED: ;
                default:    state_n = ST_IDLE;
            endcase
        end

        if (ctrl_wr)        status_n = wr_status || wr_force;
        else if (load_wr)   status_n = status;
        else if (event_hit) status_n = 1'b0;
        else if (run_out)   status_n = 1'b1;
    end

    p_load_start_r4: assert property (@(posedge clk) disable iff (rst)
        (load_wr && new_val != '0) |=> (state == ST_COUNT && cnt == $past(new_val)));

    p_run_out_r6: assert property (@(posedge clk) disable iff (rst)
        (run_out && !load_wr && !ctrl_wr && !event_hit) |=> (status && state == ST_EXPIRED));

    p_hold_expired_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXPIRED && !load_wr && !ctrl_wr && !event_hit) |=> (state == ST_EXPIRED && cnt == '0));

    p_event_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (event_hit && !load_wr && !ctrl_wr) |=> (!status && cnt == $past(load_val)));

    p_force_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_force) |=> (status && cnt == '0));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !ctrl_wr) |=> !$rose(status));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int NUM_EV = 3,
    parameter int DIV    = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1s,
    input  logic [NUM_EV-1:0] sys_evt,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [VAL_W-1:0]  wdata,
    output logic [VAL_W-1:0]  rdata,
    output logic              irq
);
    logic [VAL_W-1:0] load_val;
    logic minutes, load_wr, ctrl_wr, wr_status, wr_force, event_hit;
    logic step, status;

    wdog_regs #(.VAL_W(VAL_W), .NUM_EV(NUM_EV)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sys_evt(sys_evt), .status(status), .load_val(load_val),
        .minutes(minutes), .load_wr(load_wr), .ctrl_wr(ctrl_wr),
        .wr_status(wr_status), .wr_force(wr_force), .event_hit(event_hit),
        .rdata(rdata)
    );

    wdog_prescale #(.DIV(DIV)) u_presc (
        .clk(clk), .rst(rst), .clr(load_wr || event_hit), .tick(tick_1s),
        .minutes(minutes), .step(step)
    );

    wdog_core #(.VAL_W(VAL_W)) u_core (
        .clk(clk), .rst(rst), .new_val(wdata), .load_val(load_val),
        .load_wr(load_wr), .ctrl_wr(ctrl_wr), .wr_status(wr_status),
        .wr_force(wr_force), .event_hit(event_hit), .step(step),
        .status(status)
    );

    assign irq = status;
endmodule

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1s = 1'b0;
    logic [2:0] sys_evt = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .sys_evt(sys_evt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic t, input logic [2:0] ev);
        @(negedge clk);
        tick_1s = t; sys_evt = ev;
        @(negedge clk);
        tick_1s = 1'b0; sys_evt = '0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) pulse(1'b1, 3'b000);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check(d == 8'h00, "R1 reg after reset", d, 0);
        end
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
    endtask

    task automatic t_disabled;
        ticks(12);
        check(irq == 1'b0, "R3 zero timeout never expires", irq, 0);
    endtask

    task automatic t_seconds;
        logic [7:0] d;
        wr(2'd0, 8'd3);
        ticks(2);
        check(irq == 1'b0, "R4 before Nth tick", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R4 on Nth tick", irq, 1);
        ticks(5);
        check(irq == 1'b1, "R6 stays expired", irq, 1);
        rd(2'd2, d);
        check(d == 8'h01, "R10 status bit matches irq", d, 1);
        wr(2'd2, 8'h00);
        ticks(4);
        check(irq == 1'b0, "R6 counter stopped, no re-expiry", irq, 0);
    endtask

    task automatic t_status_write;
        wr(2'd2, 8'h01);
        check(irq == 1'b1, "R7 host sets status", irq, 1);
        wr(2'd2, 8'h00);
        check(irq == 1'b0, "R7 host clears status", irq, 0);
        wr(2'd0, 8'd9);
        wr(2'd2, 8'h01);
        check(irq == 1'b1, "R7 host sets status while counting", irq, 1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_events;
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd2);
        ticks(1);
        pulse(1'b0, 3'b001);
        ticks(1);
        check(irq == 1'b1, "R8 disabled event ignored", irq, 1);
        wr(2'd3, 8'h02);
        pulse(1'b0, 3'b010);
        check(irq == 1'b0, "R8 mouse event clears status", irq, 0);
        ticks(1);
        check(irq == 1'b0, "R8 mouse event reloaded count", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R8 reload runs out after 2", irq, 1);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h04);
        wr(2'd0, 8'd2);
        ticks(1);
        pulse(1'b0, 3'b100);
        ticks(1);
        check(irq == 1'b0, "R8 port event reloads", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R8 port event run-out", irq, 1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_force;
        logic [7:0] d;
        wr(2'd0, 8'd5);
        wr(2'd2, 8'h04);
        check(irq == 1'b1, "R9 force sets status", irq, 1);
        rd(2'd2, d);
        check(d == 8'h01, "R9 force bit reads 0", d, 1);
        wr(2'd2, 8'h00);
        ticks(6);
        check(irq == 1'b0, "R9 count zeroed and stopped", irq, 0);
    endtask

    task automatic t_minutes;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'd1);
        ticks(59);
        check(irq == 1'b0, "R5 minute not yet complete", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R5 one minute elapsed", irq, 1);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd2);
        ticks(30);
        wr(2'd0, 8'd1);
        ticks(59);
        check(irq == 1'b0, "R5 prescaler restarted on write", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R5 full minute after restart", irq, 1);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_race;
        wr(2'd3, 8'h01);
        wr(2'd0, 8'd1);
        pulse(1'b1, 3'b001);
        check(irq == 1'b0, "R11 reload beats run-out", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R11 runs out after reload", irq, 1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        wr(2'd0, 8'hA5);
        rd(2'd0, d);
        check(d == 8'hA5, "R2 timeout readback", d, 8'hA5);
        wr(2'd1, 8'hFF);
        rd(2'd1, d);
        check(d == 8'h80, "R2 units keeps bit 7", d, 8'h80);
        wr(2'd3, 8'hFF);
        rd(2'd3, d);
        check(d == 8'h07, "R2 config keeps low 3 bits", d, 8'h07);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset;
        t_disabled;
        t_seconds;
        t_status_write;
        t_events;
        t_force;
        t_minutes;
        t_race;
        t_readback;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule